// File: doc/BRIEF.md
# Audio Matrix Control-Register I2C Target

This block is the write-only control port of an audio effect matrix. A host microcontroller writes to it over a two-wire I2C bus. The block keeps four 8-bit setting registers: effect mode, space level, center level and input level. They drive the analog side directly. The block samples SCL and SDA with the system clock and finds start and stop conditions. It matches a 7-bit device address, and an address strap pin sets one bit of that address. It acknowledges each accepted byte by pulling SDA low through an open-drain enable.

After the address, the host sends a subaddress byte and then one or more data bytes. Bits 1:0 of the subaddress pick the target register. Bit 7 picks the write mode: either every data byte rewrites the same register, or the register pointer steps forward after each byte. While the pointer steps, it passes through subaddresses with bit 2 set, and data that lands there is dropped. A derived flag reports that the input path is muted.

Top module: `acr_i2c_target`

## Requirements
- R1: During and after a synchronous reset, the registers hold these values: mode 0x00 (effect off), space 0x20 (muted), center 0x20 (muted) and input 0x80 (muted).
- R2: The address byte 0x80 is accepted when `addr_sel` is 0, and 0x82 when `addr_sel` is 1. The byte's bits 7:2 are 100000, bit 1 is the strap and bit 0 (R/W) is 0. The block drives `sda_pull_low` high during the ninth SCL pulse of every accepted byte, and raises it only while SCL is low.
- R3: If the address byte does not match, or its R/W bit is 1, the block gives no acknowledge. It then ignores all bytes until the next start, and leaves every register unchanged.
- R4: The register is selected by subaddress bits 1:0: 00 mode, 01 space, 10 center, 11 input. When subaddress bit 7 is 0, every data byte up to the stop is written to that same register.
- R5: When subaddress bit 7 is 1, the pointer in bits 6:0 steps by one after each data byte. A byte whose current subaddress has bit 2 set is acknowledged but not stored.
- R6: A register is updated only after all eight data bits have been received. A stop in the middle of a byte drops that byte and returns the block to idle.
- R7: A repeated start at any point restarts address reception. No data from the interrupted transfer is stored after the repeated start.
- R8: `path_muted` equals bit 7 of the input register, the mute bit of the input-level byte. Bits 6:3 of that byte set 4 dB steps and bits 2:0 set 0.5 dB steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as seen on the wire, asynchronous |
| addr_sel | input | 1 | Address strap: 0 selects 0x80, 1 selects 0x82 |
| sda_pull_low | output | 1 | Open-drain enable; 1 pulls SDA low for acknowledge |
| mode_q | output | 8 | Mode register (bit 0 effect on, bit 1 stereo) |
| space_q | output | 8 | Space level register (bit 5 mute) |
| center_q | output | 8 | Center level register (bit 5 mute) |
| input_q | output | 8 | Input level register (bit 7 mute) |
| path_muted | output | 1 | Input path mute flag |

## Verification
Some properties are checked on every cycle: the acknowledge enable rises only while SCL is low, and it stays off while foreign traffic is being skipped. Register writes come only from the data phase, and a register with no write request keeps its value. A stop always returns the block to idle, and a start always re-arms address reception with a cleared bit count. Other behaviours need a scenario to show them. These are the address match against each strap setting, the wrapping and skipping of the auto-increment pointer, the dropped partial byte before a stop, and the discarded transfer after a repeated start. For these the bench's behavioural model is compared with the register outputs on every cycle.

// File: rtl/acr_pkg.sv
package acr_pkg;

    localparam int REG_W     = 8;
    localparam int NUM_REGS  = 4;
    localparam int SEL_W     = $clog2(NUM_REGS);
    localparam int BITS_PER  = 8;
    localparam int CNT_W     = $clog2(BITS_PER + 1);
    localparam int SYNC_LEN  = 2;

    localparam logic [5:0]       ADDR_FIXED  = 6'b100000;
    localparam logic [REG_W-1:0] RST_MODE    = 8'h00;
    localparam logic [REG_W-1:0] RST_SPACE   = 8'h20;
    localparam logic [REG_W-1:0] RST_CENTER  = 8'h20;
    localparam logic [REG_W-1:0] RST_INPUT   = 8'h80;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_SUB,
        PH_DATA,
        PH_SKIP
    } phase_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
        logic [REG_W-1:0] data;
    } wr_req_t;

    function automatic logic addr_hit(input logic [7:0] b, input logic strap);
        return (b[7:2] == ADDR_FIXED) && (b[1] == strap) && (b[0] == 1'b0);
    endfunction

    function automatic logic sub_blocked(input logic [7:0] sub);
        return sub[2];
    endfunction

    function automatic logic [7:0] sub_step(input logic [7:0] sub);
        logic [6:0] low;
        low = sub[6:0] + 7'd1;
        return {sub[7], low};
    endfunction

    function automatic logic [REG_W-1:0] reset_value(input int idx);
        case (idx)
            0:       return RST_MODE;
            1:       return RST_SPACE;
            2:       return RST_CENTER;
            default: return RST_INPUT;
        endcase
    endfunction

endpackage

// File: rtl/acr_line_sync.sv
module acr_line_sync
    import acr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] cur;
    logic [NLINES-1:0] prev;

    assign raw = {sda_in, scl_in};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic [SYNC_LEN-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain   <= '1;
                prev[g] <= 1'b1;
            end else begin
                chain   <= {chain[SYNC_LEN-2:0], raw[g]};
                prev[g] <= chain[SYNC_LEN-1];
            end
        end
        assign cur[g] = chain[SYNC_LEN-1];
    end

    always_comb begin
        ev.scl      = cur[0];
        ev.sda      = cur[1];
        ev.scl_rise = cur[0] & ~prev[0];
        ev.scl_fall = ~cur[0] & prev[0];
        ev.start    = cur[0] & prev[0] & prev[1] & ~cur[1];
        ev.stop     = cur[0] & prev[0] & ~prev[1] & cur[1];
    end

endmodule

// File: rtl/acr_bus_engine.sv
module acr_bus_engine
    import acr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bus_ev_t ev,
    input  logic    strap,
    output wr_req_t wr,
    output logic    sda_oe
);
    phase_t             phase;
    logic [CNT_W-1:0]   cnt;
    logic [BITS_PER-1:0] shreg;
    logic [7:0]         sub;
    logic               ack_pend;
    logic [7:0]         byte_now;
    logic               shifting;

    assign byte_now = {shreg[BITS_PER-2:0], ev.sda};
    assign shifting = ev.scl_rise &&
                      (phase == PH_ADDR || phase == PH_SUB || phase == PH_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            shreg    <= '0;
            sub      <= '0;
            ack_pend <= 1'b0;
            sda_oe   <= 1'b0;
            wr       <= '0;
        end else begin
            wr.en <= 1'b0;
            if (ev.start) begin
                phase    <= PH_ADDR;
                cnt      <= '0;
                ack_pend <= 1'b0;
                sda_oe   <= 1'b0;
            end else if (ev.stop) begin
                phase    <= PH_IDLE;
                cnt      <= '0;
                ack_pend <= 1'b0;
                sda_oe   <= 1'b0;
            end else begin
                if (ev.scl_fall) begin
                    if (cnt == CNT_W'(BITS_PER) && ack_pend)
                        sda_oe <= 1'b1;
                    else if (cnt == '0)
                        sda_oe <= 1'b0;
                end
                if (shifting) begin
                    if (cnt == CNT_W'(BITS_PER)) begin
                        cnt      <= '0;
                        ack_pend <= 1'b0;
                    end else begin
                        shreg <= byte_now;
                        cnt   <= cnt + 1'b1;
                        if (cnt == CNT_W'(BITS_PER - 1)) begin
                            case (phase)
                                PH_ADDR: begin
                                    if (addr_hit(byte_now, strap)) begin
                                        ack_pend <= 1'b1;
                                        phase    <= PH_SUB;
                                    end else begin
                                        phase <= PH_SKIP;
                                        cnt   <= '0;
                                    end
                                end
                                PH_SUB: begin
                                    sub      <= byte_now;
                                    ack_pend <= 1'b1;
                                    phase    <= PH_DATA;
                                end
                                PH_DATA: begin
                                    ack_pend <= 1'b1;
                                    if (!sub_blocked(sub)) begin
                                        wr.en   <= 1'b1;
                                        wr.sel  <= sub[SEL_W-1:0];
                                        wr.data <= byte_now;
                                    end
                                    if (sub[7])
                                        sub <= sub_step(sub);
                                end
                                default: ;
                            endcase
                        end
                    end
                end
            end
        end
    end

    AST_ACK_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !ev.scl); // R2

    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SKIP) |-> !sda_oe); // R3

    AST_WRITE_FROM_DATA: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> ($past(phase) == PH_DATA)); // R4

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(BITS_PER)); // R6

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (phase == PH_IDLE && !sda_oe)); // R6

    AST_START_REARM: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (phase == PH_ADDR && cnt == '0)); // R7

endmodule

// File: rtl/acr_reg_bank.sv
module acr_reg_bank
    import acr_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst,
    input  wr_req_t                            wr,
    output logic [NUM_REGS-1:0][REG_W-1:0]     regs
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= reset_value(i);
            else if (wr.en && wr.sel == SEL_W'(i))
                regs[i] <= wr.data;
        end
    end

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !wr.en |=> $stable(regs)); // R4

endmodule

// File: rtl/acr_i2c_target.sv
module acr_i2c_target
    import acr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic       addr_sel,
    output logic       sda_pull_low,
    output logic [7:0] mode_q,
    output logic [7:0] space_q,
    output logic [7:0] center_q,
    output logic [7:0] input_q,
    output logic       path_muted
);
    bus_ev_t                          ev;
    wr_req_t                          wr;
    logic [NUM_REGS-1:0][REG_W-1:0]   regs;

    acr_line_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    acr_bus_engine u_engine (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .strap  (addr_sel),
        .wr     (wr),
        .sda_oe (sda_pull_low)
    );

    acr_reg_bank u_bank (
        .clk  (clk),
        .rst  (rst),
        .wr   (wr),
        .regs (regs)
    );

    assign mode_q     = regs[0];
    assign space_q    = regs[1];
    assign center_q   = regs[2];
    assign input_q    = regs[3];
    assign path_muted = regs[3][7];

endmodule

// File: tb/acr_i2c_target_test.sv
module acr_i2c_target_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_drv = 1'b1;
    logic sda_drv = 1'b1;
    logic addr_sel = 1'b0;
    logic sda_line;
    logic sda_pull_low;
    logic [7:0] mode_q, space_q, center_q, input_q;
    logic path_muted;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    logic cmp_en = 1'b0;

    int exp_r[4];
    int ph;          // 0 idle, 1 addr, 2 sub, 3 data, 4 skip
    int sub_m;
    int ack_m;

    always #5 clk = ~clk;

    assign sda_line = sda_drv & ~sda_pull_low;

    acr_i2c_target uut (
        .clk          (clk),
        .rst          (rst),
        .scl_in       (scl_drv),
        .sda_in       (sda_line),
        .addr_sel     (addr_sel),
        .sda_pull_low (sda_pull_low),
        .mode_q       (mode_q),
        .space_q      (space_q),
        .center_q     (center_q),
        .input_q      (input_q),
        .path_muted   (path_muted)
    );

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog: run hung, actual cycle %0d expected end earlier", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            failures = failures + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic chk_regs(input string tag);
        chk({tag, " mode"},   int'(mode_q),     exp_r[0]);
        chk({tag, " space"},  int'(space_q),    exp_r[1]);
        chk({tag, " center"}, int'(center_q),   exp_r[2]);
        chk({tag, " input"},  int'(input_q),    exp_r[3]);
        chk({tag, " R8 mute"}, int'(path_muted), (exp_r[3] >> 7) & 1);
    endtask

    // per-cycle comparison against the reference model
    always @(negedge clk) begin
        if (cmp_en && !rst) begin
            checks = checks + 1;
            if (int'(mode_q) != exp_r[0] || int'(space_q) != exp_r[1] ||
                int'(center_q) != exp_r[2] || int'(input_q) != exp_r[3] ||
                int'(path_muted) != ((exp_r[3] >> 7) & 1)) begin
                failures = failures + 1;
                $display("FAIL R4 R5 R6 R7 cycle %0d: actual %h %h %h %h expected %h %h %h %h",
                         cyc, mode_q, space_q, center_q, input_q,
                         exp_r[0][7:0], exp_r[1][7:0], exp_r[2][7:0], exp_r[3][7:0]);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic model_byte(input logic [7:0] b);
        ack_m = 0;
        case (ph)
            1: begin
                if (b[7:2] == 6'b100000 && b[1] == addr_sel && b[0] == 1'b0) begin
                    ack_m = 1; ph = 2;
                end else begin
                    ph = 4;
                end
            end
            2: begin sub_m = int'(b); ack_m = 1; ph = 3; end
            3: begin
                ack_m = 1;
                if ((sub_m & 4) == 0) exp_r[sub_m & 3] = int'(b);
                if ((sub_m & 128) != 0) sub_m = 128 | ((sub_m + 1) & 127);
            end
            default: ack_m = 0;
        endcase
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; tick(8);
        scl_drv = 1'b1; tick(8);
        sda_drv = 1'b0; ph = 1; tick(8);
        scl_drv = 1'b0; tick(8);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; tick(8);
        scl_drv = 1'b1; tick(8);
        sda_drv = 1'b1; ph = 0; tick(8);
    endtask

    task automatic send_byte(input logic [7:0] b, input string tag);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; tick(8);
            scl_drv = 1'b1;
            if (i == 0) cmp_en = 1'b0;
            tick(8);
            if (i == 0) begin model_byte(b); cmp_en = 1'b1; end
            scl_drv = 1'b0; tick(2);
        end
        sda_drv = 1'b1; tick(8);
        scl_drv = 1'b1; tick(4);
        chk({tag, " ack"}, int'(sda_pull_low), ack_m);
        tick(4);
        scl_drv = 1'b0; tick(8);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_drv = b[i]; tick(8);
            scl_drv = 1'b1; tick(8);
            scl_drv = 1'b0; tick(2);
        end
    endtask

    initial begin
        exp_r[0] = 'h00; exp_r[1] = 'h20; exp_r[2] = 'h20; exp_r[3] = 'h80;
        ph = 0; sub_m = 0; ack_m = 0;
        tick(5);
        chk_regs("R1 during reset");
        rst = 1'b0;
        tick(2);
        chk_regs("R1 after reset");
        chk("R1 no drive", int'(sda_pull_low), 0);
        cmp_en = 1'b1;

        // R2 R4: single write to input register, strap 0
        bus_start();
        send_byte(8'h80, "R2 addr 0x80");
        send_byte(8'h03, "R4 sub");
        send_byte(8'h05, "R4 data");
        bus_stop();
        chk_regs("R4 input write");

        // R4: repeat writes to one register
        bus_start();
        send_byte(8'h80, "R2 addr");
        send_byte(8'h01, "R4 sub space");
        send_byte(8'h11, "R4 d1");
        send_byte(8'h07, "R4 d2");
        bus_stop();
        chk_regs("R4 no increment");
        chk("R4 space last", int'(space_q), 'h07);

        // R5: auto-increment across blocked window and wrap to mode
        bus_start();
        send_byte(8'h80, "R2 addr");
        send_byte(8'h80, "R5 sub inc");
        send_byte(8'h03, "R5 d0");
        send_byte(8'h1F, "R5 d1");
        send_byte(8'h12, "R5 d2");
        send_byte(8'h2A, "R5 d3");
        send_byte(8'hAA, "R5 blocked4");
        send_byte(8'hBB, "R5 blocked5");
        send_byte(8'hCC, "R5 blocked6");
        send_byte(8'hDD, "R5 blocked7");
        send_byte(8'h01, "R5 d8");
        bus_stop();
        chk_regs("R5 auto increment");
        chk("R5 mode", int'(mode_q), 'h01);

        // R3: wrong address and read bit
        bus_start();
        send_byte(8'h82, "R3 wrong addr");
        send_byte(8'h03, "R3 ignored sub");
        send_byte(8'h99, "R3 ignored data");
        bus_stop();
        bus_start();
        send_byte(8'h81, "R3 read bit");
        send_byte(8'h02, "R3 ignored sub2");
        send_byte(8'h00, "R3 ignored data2");
        bus_stop();
        chk_regs("R3 unchanged");

        // R2: strap high selects 0x82
        addr_sel = 1'b1;
        tick(8);
        bus_start();
        send_byte(8'h82, "R2 addr 0x82");
        send_byte(8'h02, "R2 sub center");
        send_byte(8'h0B, "R2 data");
        bus_stop();
        chk_regs("R2 strap high");
        bus_start();
        send_byte(8'h80, "R2 old addr refused");
        bus_stop();

        // R6: stop mid-byte
        bus_start();
        send_byte(8'h82, "R6 addr");
        send_byte(8'h02, "R6 sub");
        send_bits(8'hF0, 4);
        bus_stop();
        chk_regs("R6 partial dropped");
        chk("R6 center kept", int'(center_q), 'h0B);

        // R7: repeated start restarts addressing
        bus_start();
        send_byte(8'h82, "R7 addr");
        send_byte(8'h02, "R7 sub center");
        bus_start();
        send_byte(8'h82, "R7 readdr");
        send_byte(8'h03, "R7 sub input");
        send_byte(8'h85, "R7 data");
        bus_stop();
        chk_regs("R7 repeated start");
        chk("R7 center kept", int'(center_q), 'h0B);

        // R8: mute flag follows input bit 7
        chk("R8 muted set", int'(path_muted), 1);
        bus_start();
        send_byte(8'h82, "R8 addr");
        send_byte(8'h03, "R8 sub");
        send_byte(8'h7F, "R8 data");
        bus_stop();
        chk("R8 muted clear", int'(path_muted), 0);
        chk_regs("R8 final");

        cmp_en = 1'b0;
        tick(4);
        summary();
        $finish;
    end

endmodule